// File: doc/BRIEF.md
# Modem Status Register with Change Flags

This block is the modem-status byte of one UART channel. Four active-low handshake pins come into it: carrier detect, ring indicator, data-set-ready and clear-to-send. The block shows their active-high levels in the upper nibble of an 8-bit status word. The lower nibble holds sticky flags that record changes on those lines. Each pin passes through a multi-flop synchronizer. A new level is compared with the level stored on the previous cycle.

A loop-back control input swaps the pin sources for four bits of the channel's modem control byte, which comes in as `ctl_bits`. Software can then exercise the status path without touching the wires. A host read strobe returns the status word and clears every change flag in the same cycle. If a fresh change lands on that cycle, its flag survives the clear. An interrupt request is the OR of the four flags, gated by an enable input.

Top module: `modem_status_reg`

## Requirements
- R1: After reset the status word reads 0x00 and `irq` is low. Once the synchronizer has filled, the level bits show whatever the sources hold, and no change flag is set by that initial load.
- R2: In normal mode the level bits are the inverse of the pins, at these positions: bit 7 carrier (`carrier_n`), bit 6 ring (`ring_n`), bit 5 data-set-ready (`ready_n`), bit 4 clear-to-send (`clear_n`). A pin change shows up SYNC_STAGES+1 clock edges after it is sampled.
- R3: With `loop_en` high, the level bits take their values from `ctl_bits` as follows: bit 7 from `ctl_bits[3]`, bit 6 from `ctl_bits[2]`, bit 5 from `ctl_bits[0]`, bit 4 from `ctl_bits[1]`. The update lands one edge later. With `loop_en` low, `ctl_bits` has no effect on the status word.
- R4: A transition in either direction sets a flag: bit 3 for the carrier line, bit 1 for data-set-ready, bit 0 for clear-to-send.
- R5: Flag bit 2 is set only when the ring level goes from 0 to 1. A 1-to-0 ring transition sets no flag.
- R6: A flag stays set until a read. While `rd_stb` is high, the status word still shows the flags. The edge that ends the read clears them.
- R7: If a line changes on the same cycle as a read, its flag is set after that edge instead of being cleared.
- R8: Toggling `loop_en` reloads the stored levels from the newly selected sources and sets no change flag.
- R9: `irq` is high exactly when `irq_en` is high and at least one of status bits 3..0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| carrier_n | input | 1 | Carrier-detect pin, active low |
| ring_n | input | 1 | Ring-indicator pin, active low |
| ready_n | input | 1 | Data-set-ready pin, active low |
| clear_n | input | 1 | Clear-to-send pin, active low |
| loop_en | input | 1 | Take line levels from `ctl_bits` instead of the pins |
| ctl_bits | input | 4 | Modem control bits used as sources in loop-back |
| rd_stb | input | 1 | Host read strobe; clears the flags at the edge |
| irq_en | input | 1 | Enables the modem-status interrupt |
| status_word | output | 8 | Levels in bits 7..4, change flags in bits 3..0 |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench builds the block with SYNC_STAGES set to 3 instead of the default 2. Every pin-path expectation therefore has to match a latency of four edges. The post-reset warm-up window also stretches, so an initial load that leaks a flag shows up at a depth other than the default. Loop-back runs cover the one-edge path and the read-versus-change collision. Reset runs with a pin already active cover the no-flag initial load.

// File: rtl/modem_status_pkg.sv
package modem_status_pkg;

    localparam int NUM_LINES = 4;

    // Line indices; flag bit i and level bit i+NUM_LINES belong to line i
    localparam int LINE_CLEAR   = 0;
    localparam int LINE_READY   = 1;
    localparam int LINE_RING    = 2;
    localparam int LINE_CARRIER = 3;

    typedef logic [NUM_LINES-1:0] line_vec_t;

    typedef enum logic {
        EDGE_ANY  = 1'b0,
        EDGE_RISE = 1'b1
    } edge_kind_e;

    // Which transitions raise the change flag of a line
    function automatic edge_kind_e line_edge_kind(input int line);
        return (line == LINE_RING) ? EDGE_RISE : EDGE_ANY;
    endfunction

    // Control bit feeding a line in loop-back
    function automatic int loop_src_bit(input int line);
        case (line)
            LINE_CLEAR:   return 1;
            LINE_READY:   return 0;
            LINE_RING:    return 2;
            default:      return 3;
        endcase
    endfunction

endpackage

// File: rtl/ms_sync.sv
module ms_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    // Reset to all ones: the inactive level of active-low pins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/ms_source_sel.sv
module ms_source_sel
    import modem_status_pkg::*;
(
    input  logic      loop_en,
    input  logic [3:0] ctl_bits,
    input  line_vec_t synced_n,
    output line_vec_t cur_level
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        localparam int SRC = loop_src_bit(i);
        assign cur_level[i] = loop_en ? ctl_bits[SRC] : ~synced_n[i];
    end
endmodule

// File: rtl/ms_change_det.sv
module ms_change_det
    import modem_status_pkg::*;
(
    input  logic      det_en,
    input  line_vec_t cur_level,
    input  line_vec_t prev_level,
    output line_vec_t evt
);
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (line_edge_kind(i) == EDGE_RISE) begin : g_rise
            assign evt[i] = det_en & cur_level[i] & ~prev_level[i];
        end else begin : g_any
            assign evt[i] = det_en & (cur_level[i] ^ prev_level[i]);
        end
    end
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg
    import modem_status_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       carrier_n,
    input  logic       ring_n,
    input  logic       ready_n,
    input  logic       clear_n,
    input  logic       loop_en,
    input  logic [3:0] ctl_bits,
    input  logic       rd_stb,
    input  logic       irq_en,
    output logic [7:0] status_word,
    output logic       irq
);
    // Warm-up spans the synchronizer fill plus one load of the stored levels
    localparam int WARM_LIMIT = SYNC_STAGES + 1;
    localparam int WARM_W     = $clog2(WARM_LIMIT + 1);

    typedef struct packed {
        line_vec_t         level;
        line_vec_t         flags;
        logic              mode;
        logic [WARM_W-1:0] warm;
    } state_t;

    state_t    st_d, st_q;
    line_vec_t pins_n, synced_n, cur_level, det_evt;
    logic      armed, mode_q, det_en;

    assign pins_n = {carrier_n, ring_n, ready_n, clear_n};

    ms_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_n),
        .dout  (synced_n)
    );

    ms_source_sel u_sel (
        .loop_en   (loop_en),
        .ctl_bits  (ctl_bits),
        .synced_n  (synced_n),
        .cur_level (cur_level)
    );

    assign armed  = (st_q.warm == WARM_W'(WARM_LIMIT));
    assign mode_q = st_q.mode;
    assign det_en = armed & (loop_en == st_q.mode);

    ms_change_det u_det (
        .det_en     (det_en),
        .cur_level  (cur_level),
        .prev_level (st_q.level),
        .evt        (det_evt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.level = cur_level;
        st_d.mode  = loop_en;
        st_d.flags = (rd_stb ? '0 : st_q.flags) | det_evt;
        if (!armed) st_d.warm = st_q.warm + WARM_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_word = {st_q.level, st_q.flags};
    assign irq         = irq_en & (|st_q.flags);
endmodule

// File: rtl/ms_checker.sv
module ms_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       loop_en,
    input logic [3:0] ctl_bits,
    input logic       rd_stb,
    input logic       irq_en,
    input logic [7:0] status_word,
    input logic       irq,
    input logic [3:0] det_evt,
    input logic       mode_q
);
    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    p_irq_any_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && (status_word[3:0] != 4'h0)) |-> irq);

    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ((status_word[3:0] & $past(status_word[3:0])) == $past(status_word[3:0])));

    p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && det_evt == 4'h0) |=> (status_word[3:0] == 4'h0));

    p_collide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && det_evt != 4'h0) |=> (status_word[3:0] != 4'h0));

    p_ring_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_word[2]) |-> status_word[6]);

    p_loop_map_r3: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |=> (status_word[7:4] ==
            {$past(ctl_bits[3]), $past(ctl_bits[2]), $past(ctl_bits[0]), $past(ctl_bits[1])}));

    p_mode_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (loop_en != mode_q) |=> ((status_word[3:0] & ~$past(status_word[3:0])) == 4'h0));
endmodule

bind modem_status_reg ms_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .loop_en     (loop_en),
    .ctl_bits    (ctl_bits),
    .rd_stb      (rd_stb),
    .irq_en      (irq_en),
    .status_word (status_word),
    .irq         (irq),
    .det_evt     (det_evt),
    .mode_q      (mode_q)
);

// File: tb/modem_status_reg_bench.sv
module modem_status_reg_bench;
    localparam int SYNC = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       carrier_n = 1'b1, ring_n = 1'b1, ready_n = 1'b1, clear_n = 1'b1;
    logic       loop_en = 1'b0;
    logic [3:0] ctl_bits = 4'h0;
    logic       rd_stb = 1'b0;
    logic       irq_en = 1'b1;
    logic [7:0] status_word;
    logic       irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    modem_status_reg #(.SYNC_STAGES(SYNC)) u_modem_status_reg (
        .clk(clk), .rst_n(rst_n),
        .carrier_n(carrier_n), .ring_n(ring_n), .ready_n(ready_n), .clear_n(clear_n),
        .loop_en(loop_en), .ctl_bits(ctl_bits), .rd_stb(rd_stb), .irq_en(irq_en),
        .status_word(status_word), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_read(input string req, input logic [7:0] exp_word);
        rd_stb = 1'b1;
        check(req, status_word, exp_word);
        tick(1);
        rd_stb = 1'b0;
        check(req, status_word, {exp_word[7:4], 4'h0});
    endtask

    // R1: reset state and no-flag initial load with carrier already active
    task automatic t_reset();
        carrier_n = 1'b0;
        rst_n = 1'b0;
        tick(4);
        check("R1 reset word", status_word, 8'h00);
        check("R1 reset irq", {7'h0, irq}, 8'h00);
        rst_n = 1'b1;
        tick(SYNC + 3);
        check("R1 initial load", status_word, 8'h80);
        carrier_n = 1'b1;
        tick(SYNC + 1);
        check("R4 carrier fall", status_word, 8'h08);
        do_read("R6 read carrier", 8'h08);
    endtask

    // R2 R4 R9: levels and any-direction flags in normal mode
    task automatic t_normal();
        carrier_n = 1'b0;
        tick(SYNC + 1);
        check("R2 R4 carrier rise", status_word, 8'h88);
        do_read("R6 read", 8'h88);
        ready_n = 1'b0;
        clear_n = 1'b0;
        tick(SYNC + 1);
        check("R2 R4 ready/clear", status_word, 8'hB3);
        check("R9 irq on", {7'h0, irq}, 8'h01);
        irq_en = 1'b0;
        #1;
        check("R9 irq gated", {7'h0, irq}, 8'h00);
        irq_en = 1'b1;
        tick(3);
        check("R6 sticky", status_word, 8'hB3);
        do_read("R6 read two", 8'hB3);
        check("R9 irq off", {7'h0, irq}, 8'h00);
        carrier_n = 1'b1;
        ready_n = 1'b1;
        clear_n = 1'b1;
        tick(SYNC + 1);
        check("R4 falls", status_word, 8'h0B);
        do_read("R6 read three", 8'h0B);
    endtask

    // R5: ring flags only on rising level
    task automatic t_ring();
        ring_n = 1'b0;
        tick(SYNC + 1);
        check("R5 ring rise", status_word, 8'h44);
        do_read("R5 read", 8'h44);
        ring_n = 1'b1;
        tick(SYNC + 1);
        check("R5 ring fall no flag", status_word, 8'h00);
    endtask

    // R3 R8: loop-back mapping and quiet mode switch
    task automatic t_loop();
        ctl_bits = 4'hF;
        tick(3);
        check("R3 ctl ignored normal", status_word, 8'h00);
        loop_en = 1'b1;
        tick(1);
        check("R8 switch in quiet", status_word, 8'hF0);
        ctl_bits = 4'b0001;
        tick(1);
        check("R3 bit0 to bit5", status_word, 8'h29);
        do_read("R3 read", 8'h29);
        ctl_bits = 4'b0010;
        tick(1);
        check("R3 bit1 to bit4", status_word, 8'h13);
        do_read("R3 read two", 8'h13);
    endtask

    // R7: change on the read cycle survives; R8 switch back
    task automatic t_collide();
        ctl_bits = 4'b1010;
        rd_stb = 1'b1;
        check("R7 pre-read word", status_word, 8'h10);
        tick(1);
        rd_stb = 1'b0;
        check("R7 flag kept", status_word, 8'h98);
        do_read("R7 read", 8'h98);
        loop_en = 1'b0;
        tick(1);
        check("R8 switch out quiet", status_word, 8'h00);
        tick(2);
        check("R8 still quiet", status_word, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_normal();
        t_ring();
        t_loop();
        t_collide();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule